// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the home node for a distributed shared memory with up to eight caching nodes. It holds a directory entry for every memory block it owns, and it holds the memory data for those blocks. A directory entry has a sharing state (uncached, shared or exclusive), a sharer bit vector with one bit per node, and the encoded ID of the owner. Cache-side controllers send read-miss, write-miss and write-back messages to the block. In return it sends data replies, invalidation multicasts and fetch commands. The network is represented only by these message ports.

The controller handles one request at a time. A request that finds the block held exclusive by another cache sends a fetch to the owner. The controller then waits for the owner's data and lowers `req_ready`, so every other request waits at the port until that data arrives. Every other transition finishes within one cycle. Its messages come out one cycle after the request is accepted.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is uncached with an empty sharer vector and all-zero memory data, `req_ready` is 1, and no message valid is asserted.
- R2: A read miss (`req_type` 0) on an uncached block returns the memory data to the requester, leaves the requester as the only sharer, and moves the block to shared.
- R3: A write miss (`req_type` 1) on an uncached block returns the memory data, makes the requester the owner, and moves the block to exclusive.
- R4: A read miss on a shared block returns the memory data and adds the requester to the sharer vector. The block stays shared.
- R5: A write miss on a shared block returns the memory data and sends one invalidation whose mask (bit i = node i) holds every sharer except the requester. No invalidation is sent when that mask is empty. The block becomes exclusive with the requester as owner.
- R6: A read miss on an exclusive block sends a fetch with `fch_inval`=0 to the owner. When the owner's data arrives, that data is written to memory and forwarded to the requester, and the block becomes shared by the old owner and the requester.
- R7: A write miss on an exclusive block sends a fetch with `fch_inval`=1 to the owner. When the owner's data arrives, it is forwarded to the requester, the requester becomes the owner, and the block stays exclusive.
- R8: A write-back (`req_type` 2) from the owner of an exclusive block writes `req_data` to memory, clears the sharer vector and moves the block to uncached. No message is sent.
- R9: A write-back from a node that is not the owner, a write-back to a block that is not exclusive, and `req_type` 3 are all ignored. No message is sent and the directory is left unchanged.
- R10: From the cycle after a fetch is issued until the cycle after the owner's data is accepted, `req_ready` is 0 and requests are neither answered nor consumed. `rsp_valid` has no effect while no fetch is outstanding.
- R11: Every message is a one-cycle pulse. It appears in the cycle after the request or owner response that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Incoming request present |
| req_ready | output | 1 | Controller can accept a request |
| req_type | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 ignored |
| req_node | input | $clog2(NODES) | Requesting node ID |
| req_blk | input | $clog2(BLOCKS) | Block index |
| req_data | input | DATA_W | Write-back data |
| rsp_valid | input | 1 | Owner data returned for the outstanding fetch |
| rsp_data | input | DATA_W | Owner data |
| rep_valid | output | 1 | Data reply pulse |
| rep_node | output | $clog2(NODES) | Reply destination |
| rep_data | output | DATA_W | Reply data |
| inv_valid | output | 1 | Invalidation multicast pulse |
| inv_mask | output | NODES | Nodes to invalidate |
| fch_valid | output | 1 | Fetch command pulse |
| fch_node | output | $clog2(NODES) | Owner that is fetched |
| fch_inval | output | 1 | Owner must also invalidate its copy |

## Verification
The bench drives random traffic onto a few blocks so that every block cycles through all three states. Along the way the traffic produces write misses from a node that is already a sharer, fetches aimed at a node that is itself the requester, write-backs from the wrong node, and requests held at the port during a fetch. A design that kept the requester in the invalidation mask would invalidate the very copy it had just granted. One that ignored ownership on write-back would drop a valid exclusive copy. One that did not stall during a fetch would answer a request with stale memory data. The bench also sends stray owner responses and delays real ones by a random number of cycles, so a controller that accepts an unsolicited response, or releases the stall too early, produces a reply the model does not predict.

// File: rtl/dir_pkg.sv
package dir_pkg;
   typedef enum logic [1:0] {
      DS_UNCACHED = 2'd0,
      DS_SHARED   = 2'd1,
      DS_EXCL     = 2'd2
   } dstate_e;

   localparam logic [1:0] RQ_READ  = 2'd0;
   localparam logic [1:0] RQ_WRITE = 2'd1;
   localparam logic [1:0] RQ_WBACK = 2'd2;
endpackage

// File: rtl/dir_regfile.sv
module dir_regfile #(
   parameter int W     = 8,
   parameter int DEPTH = 16,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   if (DEPTH != (1 << AW)) begin : g_chk
      $error("dir_regfile: DEPTH must be a power of two");
   end

   logic [W-1:0] q [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n)                         q[i] <= '0;
         else if (we && waddr == AW'(i))     q[i] <= wdata;
      end
   end

   assign rdata = q[raddr];
endmodule

// File: rtl/dir_decide.sv
module dir_decide
   import dir_pkg::*;
#(
   parameter int NODES  = 8,
   parameter int DATA_W = 32,
   localparam int NW    = $clog2(NODES)
) (
   input  logic              busy,
   input  logic              req_valid,
   input  logic [1:0]        req_type,
   input  logic [NW-1:0]     req_node,
   input  logic [DATA_W-1:0] req_data,
   input  logic              rsp_valid,
   input  logic [DATA_W-1:0] rsp_data,
   input  logic [NW-1:0]     pend_node,
   input  logic              pend_wr,
   input  dstate_e           cur_st,
   input  logic [NODES-1:0]  cur_shr,
   input  logic [NW-1:0]     cur_own,
   input  logic [DATA_W-1:0] cur_mem,
   output logic              start_fetch,
   output logic              finish_fetch,
   output logic              dir_we,
   output dstate_e           nxt_st,
   output logic [NODES-1:0]  nxt_shr,
   output logic [NW-1:0]     nxt_own,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              o_rep,
   output logic [NW-1:0]     o_rep_node,
   output logic [DATA_W-1:0] o_rep_data,
   output logic              o_inv,
   output logic [NODES-1:0]  o_inv_mask,
   output logic              o_fch,
   output logic [NW-1:0]     o_fch_node,
   output logic              o_fch_inv
);
   localparam logic [NODES-1:0] ONE = NODES'(1);

   logic [NODES-1:0] req_oh, pend_oh, own_oh, others;
   assign req_oh  = ONE << req_node;
   assign pend_oh = ONE << pend_node;
   assign own_oh  = ONE << cur_own;
   assign others  = cur_shr & ~req_oh;

   always_comb begin
      start_fetch  = 1'b0;
      finish_fetch = 1'b0;
      dir_we       = 1'b0;
      nxt_st       = cur_st;
      nxt_shr      = cur_shr;
      nxt_own      = cur_own;
      mem_we       = 1'b0;
      mem_wdata    = req_data;
      o_rep        = 1'b0;
      o_rep_node   = req_node;
      o_rep_data   = cur_mem;
      o_inv        = 1'b0;
      o_inv_mask   = others;
      o_fch        = 1'b0;
      o_fch_node   = cur_own;
      o_fch_inv    = 1'b0;
      if (busy) begin
         if (rsp_valid) begin
            finish_fetch = 1'b1;
            dir_we       = 1'b1;
            mem_we       = 1'b1;
            mem_wdata    = rsp_data;
            o_rep        = 1'b1;
            o_rep_node   = pend_node;
            o_rep_data   = rsp_data;
            if (pend_wr) begin
               nxt_st  = DS_EXCL;
               nxt_shr = pend_oh;
               nxt_own = pend_node;
            end else begin
               nxt_st  = DS_SHARED;
               nxt_shr = own_oh | pend_oh;
            end
         end
      end else if (req_valid) begin
         unique case (req_type)
            RQ_READ, RQ_WRITE: begin
               if (cur_st == DS_EXCL) begin
                  start_fetch = 1'b1;
                  o_fch       = 1'b1;
                  o_fch_inv   = (req_type == RQ_WRITE);
               end else begin
                  dir_we = 1'b1;
                  o_rep  = 1'b1;
                  if (req_type == RQ_READ) begin
                     nxt_st  = DS_SHARED;
                     nxt_shr = (cur_st == DS_SHARED) ? (cur_shr | req_oh) : req_oh;
                  end else begin
                     nxt_st  = DS_EXCL;
                     nxt_shr = req_oh;
                     nxt_own = req_node;
                     o_inv   = (cur_st == DS_SHARED) && (others != '0);
                  end
               end
            end
            RQ_WBACK: begin
               if (cur_st == DS_EXCL && cur_own == req_node) begin
                  dir_we  = 1'b1;
                  mem_we  = 1'b1;
                  nxt_st  = DS_UNCACHED;
                  nxt_shr = '0;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
   import dir_pkg::*;
#(
   parameter int NODES  = 8,
   parameter int BLOCKS = 16,
   parameter int DATA_W = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   output logic                      req_ready,
   input  logic [1:0]                req_type,
   input  logic [$clog2(NODES)-1:0]  req_node,
   input  logic [$clog2(BLOCKS)-1:0] req_blk,
   input  logic [DATA_W-1:0]         req_data,
   input  logic                      rsp_valid,
   input  logic [DATA_W-1:0]         rsp_data,
   output logic                      rep_valid,
   output logic [$clog2(NODES)-1:0]  rep_node,
   output logic [DATA_W-1:0]         rep_data,
   output logic                      inv_valid,
   output logic [NODES-1:0]          inv_mask,
   output logic                      fch_valid,
   output logic [$clog2(NODES)-1:0]  fch_node,
   output logic                      fch_inval
);
   localparam int NW = $clog2(NODES);
   localparam int BW = $clog2(BLOCKS);
   localparam int EW = 2 + NODES + NW;

   if (NODES < 2 || NODES > 8) begin : g_nodes_chk
      $error("dir_home_ctrl: NODES must lie in 2..8");
   end
   if (BLOCKS < 2) begin : g_blk_chk
      $error("dir_home_ctrl: BLOCKS must be at least 2");
   end

   logic          busy, pend_wr;
   logic [BW-1:0] pend_blk, raddr;
   logic [NW-1:0] pend_node;

   assign req_ready = !busy;
   assign raddr     = busy ? pend_blk : req_blk;

   logic [EW-1:0]     ent_rd, ent_wr;
   logic [DATA_W-1:0] mem_rd, mem_wd;
   dstate_e           cur_st, nxt_st;
   logic [NODES-1:0]  cur_shr, nxt_shr;
   logic [NW-1:0]     cur_own, nxt_own;
   logic              dir_we, mem_we, start_fetch, finish_fetch;

   assign cur_st  = dstate_e'(ent_rd[EW-1 -: 2]);
   assign cur_shr = ent_rd[NW +: NODES];
   assign cur_own = ent_rd[NW-1:0];
   assign ent_wr  = {nxt_st, nxt_shr, nxt_own};

   dir_regfile #(.W(EW), .DEPTH(BLOCKS)) u_dir (
      .clk(clk), .rst_n(rst_n), .we(dir_we), .waddr(raddr),
      .wdata(ent_wr), .raddr(raddr), .rdata(ent_rd));

   dir_regfile #(.W(DATA_W), .DEPTH(BLOCKS)) u_mem (
      .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(raddr),
      .wdata(mem_wd), .raddr(raddr), .rdata(mem_rd));

   logic              n_rep, n_inv, n_fch, n_fch_inv;
   logic [NW-1:0]     n_rep_node, n_fch_node;
   logic [DATA_W-1:0] n_rep_data;
   logic [NODES-1:0]  n_inv_mask;

   dir_decide #(.NODES(NODES), .DATA_W(DATA_W)) u_dec (
      .busy(busy), .req_valid(req_valid), .req_type(req_type),
      .req_node(req_node), .req_data(req_data),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .pend_node(pend_node), .pend_wr(pend_wr),
      .cur_st(cur_st), .cur_shr(cur_shr), .cur_own(cur_own), .cur_mem(mem_rd),
      .start_fetch(start_fetch), .finish_fetch(finish_fetch),
      .dir_we(dir_we), .nxt_st(nxt_st), .nxt_shr(nxt_shr), .nxt_own(nxt_own),
      .mem_we(mem_we), .mem_wdata(mem_wd),
      .o_rep(n_rep), .o_rep_node(n_rep_node), .o_rep_data(n_rep_data),
      .o_inv(n_inv), .o_inv_mask(n_inv_mask),
      .o_fch(n_fch), .o_fch_node(n_fch_node), .o_fch_inv(n_fch_inv));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         pend_wr   <= 1'b0;
         pend_blk  <= '0;
         pend_node <= '0;
         rep_valid <= 1'b0;
         rep_node  <= '0;
         rep_data  <= '0;
         inv_valid <= 1'b0;
         inv_mask  <= '0;
         fch_valid <= 1'b0;
         fch_node  <= '0;
         fch_inval <= 1'b0;
      end else begin
         if (start_fetch) begin
            busy      <= 1'b1;
            pend_blk  <= req_blk;
            pend_node <= req_node;
            pend_wr   <= (req_type == RQ_WRITE);
         end else if (finish_fetch) begin
            busy <= 1'b0;
         end
         rep_valid <= n_rep;
         inv_valid <= n_inv;
         fch_valid <= n_fch;
         if (n_rep) begin
            rep_node <= n_rep_node;
            rep_data <= n_rep_data;
         end
         if (n_inv) inv_mask <= n_inv_mask;
         if (n_fch) begin
            fch_node  <= n_fch_node;
            fch_inval <= n_fch_inv;
         end
      end
   end

   AST_FETCH_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      fch_valid |-> !req_ready);                                            // R10
   AST_FETCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      fch_valid |=> !fch_valid);                                            // R11
   AST_INV_SPARES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid |-> (rep_valid && !inv_mask[rep_node] && inv_mask != '0));  // R5
   AST_FETCH_NO_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
      !(fch_valid && rep_valid));                                           // R6
   AST_RSP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && rsp_valid) |=> (rep_valid && req_ready));              // R6
   AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && !rsp_valid) |=> !rep_valid && !inv_valid && !fch_valid); // R10
endmodule

// File: tb/dir_home_ctrl_test.sv
module dir_home_ctrl_test;
   localparam int NODES  = 8;
   localparam int BLOCKS = 16;
   localparam int DW     = 32;
   localparam int USEB   = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          req_valid = 0, rsp_valid = 0;
   logic [1:0]    req_type = 0;
   logic [2:0]    req_node = 0;
   logic [3:0]    req_blk = 0;
   logic [DW-1:0] req_data = 0, rsp_data = 0;
   logic          req_ready, rep_valid, inv_valid, fch_valid, fch_inval;
   logic [2:0]    rep_node, fch_node;
   logic [DW-1:0] rep_data;
   logic [7:0]    inv_mask;

   dir_home_ctrl #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_type(req_type), .req_node(req_node), .req_blk(req_blk),
      .req_data(req_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .rep_valid(rep_valid), .rep_node(rep_node), .rep_data(rep_data),
      .inv_valid(inv_valid), .inv_mask(inv_mask), .fch_valid(fch_valid),
      .fch_node(fch_node), .fch_inval(fch_inval));

   int n_checks = 0, n_fail = 0;

   // model: 0 uncached, 1 shared, 2 exclusive
   int            m_st  [BLOCKS];
   logic [7:0]    m_shr [BLOCKS];
   int            m_own [BLOCKS];
   logic [DW-1:0] m_mem [BLOCKS];
   bit            m_busy = 0, m_pwr = 0;
   int            m_pb = 0, m_pn = 0;
   bit            e_rep, e_inv, e_fch, e_fiv;
   int            e_rn, e_fn;
   logic [DW-1:0] e_rd;
   logic [7:0]    e_im;
   string         tag;

   task automatic chk(string t, bit ok, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
      end
   endtask

   function automatic logic [7:0] oh(int n);
      return 8'(1) << n;
   endfunction

   task automatic model_step();
      e_rep = 0; e_inv = 0; e_fch = 0; e_fiv = 0;
      tag = "R11";
      if (m_busy) begin
         if (rsp_valid) begin
            e_rep = 1; e_rn = m_pn; e_rd = rsp_data;
            m_mem[m_pb] = rsp_data;
            if (m_pwr) begin
               m_st[m_pb] = 2; m_shr[m_pb] = oh(m_pn); m_own[m_pb] = m_pn; tag = "R7";
            end else begin
               m_st[m_pb] = 1; m_shr[m_pb] = oh(m_own[m_pb]) | oh(m_pn); tag = "R6";
            end
            m_busy = 0;
         end else tag = "R10";
      end else if (req_valid) begin
         int b = int'(req_blk);
         int n = int'(req_node);
         if (req_type <= 1) begin
            if (m_st[b] == 2) begin
               e_fch = 1; e_fn = m_own[b]; e_fiv = (req_type == 1);
               m_busy = 1; m_pb = b; m_pn = n; m_pwr = (req_type == 1);
               tag = (req_type == 1) ? "R7" : "R6";
            end else begin
               e_rep = 1; e_rn = n; e_rd = m_mem[b];
               if (req_type == 0) begin
                  tag = (m_st[b] == 1) ? "R4" : "R2";
                  m_shr[b] = (m_st[b] == 1) ? (m_shr[b] | oh(n)) : oh(n);
                  m_st[b] = 1;
               end else begin
                  tag = (m_st[b] == 1) ? "R5" : "R3";
                  if (m_st[b] == 1 && (m_shr[b] & ~oh(n)) != 0) begin
                     e_inv = 1; e_im = m_shr[b] & ~oh(n);
                  end
                  m_st[b] = 2; m_shr[b] = oh(n); m_own[b] = n;
               end
            end
         end else if (req_type == 2 && m_st[b] == 2 && m_own[b] == n) begin
            tag = "R8";
            m_mem[b] = req_data; m_st[b] = 0; m_shr[b] = 0;
         end else tag = "R9";
      end
   endtask

   task automatic compare();
      chk(tag, rep_valid === e_rep, "rep_valid", DW'(rep_valid), DW'(e_rep));
      if (e_rep && rep_valid) begin
         chk(tag, rep_node === 3'(e_rn), "rep_node", DW'(rep_node), DW'(e_rn));
         chk(tag, rep_data === e_rd, "rep_data", rep_data, e_rd);
      end
      chk(tag, inv_valid === e_inv, "inv_valid", DW'(inv_valid), DW'(e_inv));
      if (e_inv && inv_valid) chk(tag, inv_mask === e_im, "inv_mask", DW'(inv_mask), DW'(e_im));
      chk(tag, fch_valid === e_fch, "fch_valid", DW'(fch_valid), DW'(e_fch));
      if (e_fch && fch_valid) begin
         chk(tag, fch_node === 3'(e_fn), "fch_node", DW'(fch_node), DW'(e_fn));
         chk(tag, fch_inval === e_fiv, "fch_inval", DW'(fch_inval), DW'(e_fiv));
      end
      chk("R10", req_ready === !m_busy, "req_ready", DW'(req_ready), DW'(!m_busy));
   endtask

   int wait_cnt = 0;
   bit done = 0;

   initial begin
      for (int i = 0; i < BLOCKS; i++) begin
         m_st[i] = 0; m_shr[i] = 0; m_own[i] = 0; m_mem[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", req_ready === 1'b1, "req_ready after reset", DW'(req_ready), 1);
      chk("R1", {rep_valid, inv_valid, fch_valid} === 3'b000, "valids after reset",
          DW'({rep_valid, inv_valid, fch_valid}), 0);
      for (int cyc = 0; cyc < 4000; cyc++) begin
         // drive inputs for next edge
         req_valid = ($urandom_range(0, 3) != 0);
         req_type  = 2'($urandom_range(0, 9) < 4 ? 0 : ($urandom_range(0, 5) < 3 ? 1 :
                     ($urandom_range(0, 7) == 0 ? 3 : 2)));
         req_node  = 3'($urandom_range(0, NODES - 1));
         req_blk   = 4'($urandom_range(0, USEB - 1));
         req_data  = $urandom;
         rsp_data  = $urandom;
         if (m_busy) begin
            if (wait_cnt == 0) rsp_valid = 1;
            else begin rsp_valid = 0; wait_cnt--; end
         end else begin
            rsp_valid = ($urandom_range(0, 15) == 0); // stray, must be ignored (R10)
            wait_cnt  = $urandom_range(0, 3);
         end
         @(posedge clk);
         model_step();
         @(negedge clk);
         compare();
      end
      req_valid = 0; rsp_valid = 0;
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog R11 actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end
endmodule